// File: doc/BRIEF.md
# Strobed Multichannel Result Readout Port

This block is the output side of a multichannel sampling converter. A set of conversion results is held on a wide input bus, one word per channel. An external host reads them through a chip-select and read-strobe pair. Each read strobe, taken while the chip is selected, moves the port to the next channel in ascending order, from channel 1 up to the last, and then back to channel 1. In word mode every strobe returns a whole result. In byte mode every strobe returns half a result on the low eight lines. A pin picks whether the upper or the lower half of each result comes first.

Next to the data the port drives a first-channel marker, so that the host can realign its count of channels. The data enable follows the select and strobe pins without delay. The data and the marker are registered on the first clock edge that sees the strobe low. A pulse on the new-result input, which comes from the conversion logic when fresh results are latched, moves the port back to channel 1. All pins are taken to be synchronous to `clk`. The pad drivers sit outside the block, and while an enable is low the value behind it is driven to zero.

Top module: `par_result_port`

## Requirements
- R1: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. While `data_oe` is 0, `data_out` is all zeros.
- R2: In word mode (`byte_mode`=0) each read (a 1-to-0 change of `rd_n` with `cs_n`=0) presents the next channel in ascending order, channel 1 first, as the whole W-bit result. The result is valid from the first clock edge at which `rd_n` is sampled 0 and holds while `rd_n` stays 0.
- R3: A read that follows the one presenting the last channel presents channel 1 again.
- R4: In byte mode (`byte_mode`=1) each result takes two reads. The byte is on `data_out[7:0]` and `data_out[15:8]` is 0. The channel advances only after the second byte has been read.
- R5: In byte mode with `hi_first`=1, the first read of a channel returns result bits 15:8 and the second read returns bits 7:0. With `hi_first`=0 the order is reversed.
- R6: `flag_oe` is 1 exactly while `cs_n` is 0. While `cs_n` is 0 the marker starts low.
- R7: `first_flag` is 1 while channel 1 is on the bus: for one read in word mode, and for both byte reads in byte mode. It falls on the read that presents channel 2.
- R8: When `cs_n` and `rd_n` fall and rise together, each combined low pulse reads one channel.
- R9: A one-cycle `new_result` pulse returns the port to channel 1 and to the first byte of that channel.
- R10: After reset the next read presents channel 1, first byte, and the marker is low until that read.
- R11: `rd_n` pulses while `cs_n` is 1 do not advance the channel and drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| byte_mode | input | 1 | 1: byte reads, 0: word reads |
| hi_first | input | 1 | Byte mode: 1 returns the upper byte first |
| new_result | input | 1 | One-cycle pulse when fresh results are latched |
| results | input | NCH*W | Result words; channel 1 in the lowest W bits |
| data_out | output | W | Read data; zero when not enabled |
| data_oe | output | 1 | Data bus drive enable |
| first_flag | output | 1 | High while channel 1 is on the bus |
| flag_oe | output | 1 | Marker drive enable |

## Verification
The bench builds the port with NCH=8 and W=16. With these values a run of reads crosses the wrap from channel 8 back to channel 1 many times. A byte-mode run takes sixteen strobes per set of results, so the byte order and the point where the marker falls both show up under random changes of mode. Results are reloaded at random through `new_result`, some of them in the middle of a channel. This puts the restart behaviour against partly read byte pairs.

// File: rtl/par_result_port.sv
module par_result_port #(
  parameter int NCH = 8,
  parameter int W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             byte_mode,
  input  logic             hi_first,
  input  logic             new_result,
  input  logic [NCH*W-1:0] results,
  output logic [W-1:0]     data_out,
  output logic             data_oe,
  output logic             first_flag,
  output logic             flag_oe
);
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BW = W / 2;

  logic          rd_q, half, flag_q;
  logic [PW-1:0] ptr;
  logic [W-1:0]  out_q;

  wire           rd_fall = rd_q & ~rd_n & ~cs_n;
  wire [W-1:0]   word    = results[int'(ptr)*W +: W];
  wire           pick_hi = (half != hi_first);
  wire [BW-1:0]  sel     = pick_hi ? word[W-1:BW] : word[BW-1:0];
  wire           last    = (ptr == PW'(NCH-1));
  wire [PW-1:0]  nxt     = last ? '0 : ptr + 1'b1;

  assign data_oe    = ~cs_n & ~rd_n;
  assign data_out   = data_oe ? out_q : '0;
  assign flag_oe    = ~cs_n;
  assign first_flag = flag_oe & flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b1;
      ptr    <= '0;
      half   <= 1'b0;
      out_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      rd_q <= rd_n;
      if (new_result) begin
        ptr    <= '0;
        half   <= 1'b0;
        flag_q <= 1'b0;
      end else if (cs_n) begin
        flag_q <= 1'b0;
      end else if (rd_fall) begin
        flag_q <= (ptr == '0);
        if (byte_mode) begin
          out_q <= {{(W-BW){1'b0}}, sel};
          half  <= ~half;
          if (half) ptr <= nxt;
        end else begin
          out_q <= word;
          half  <= 1'b0;
          ptr   <= nxt;
        end
      end
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NCH); // R3
  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !new_result && !byte_mode && last) |=> (ptr == '0)); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    new_result |=> (ptr == '0 && !half)); // R9
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fall && !new_result) |=> $stable(out_q) && $stable(ptr)); // R11
  AST_FLAG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(rd_fall)); // R7
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && byte_mode && !new_result) |=> (out_q[W-1:BW] == '0)); // R4
endmodule

// File: tb/sim_par_result_port.sv
module sim_par_result_port;
  localparam int NCH = 8;
  localparam int W   = 16;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, byte_mode = 0, hi_first = 1, new_result = 0;
  logic [NCH*W-1:0] results = '0;
  logic [W-1:0] data_out;
  logic data_oe, first_flag, flag_oe;

  int n_tests = 0, n_fail = 0;
  int m_ptr = 0;
  bit m_half = 0;

  always #5 clk = ~clk;

  par_result_port #(.NCH(NCH), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .byte_mode(byte_mode),
    .hi_first(hi_first), .new_result(new_result), .results(results),
    .data_out(data_out), .data_oe(data_oe), .first_flag(first_flag), .flag_oe(flag_oe));

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_data(int p, bit h, bit bm, bit hf);
    logic [W-1:0] w = results[p*W +: W];
    if (!bm) return w;
    return (h != hf) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic load(bit corner);
    @(negedge clk);
    for (int c = 0; c < NCH; c++)
      results[c*W +: W] = corner ? ((c % 2) ? 16'h7FFF : 16'h8000) : W'($urandom);
    new_result = 1;
    @(negedge clk);
    new_result = 0;
    m_ptr = 0; m_half = 0;
  endtask

  task automatic do_read(bit linked, string req);
    logic [W-1:0] e = exp_data(m_ptr, m_half, byte_mode, hi_first);
    logic ef = (m_ptr == 0);
    @(negedge clk);
    if (linked) cs_n = 0;
    rd_n = 0;
    @(negedge clk);
    check({req, " data"}, data_out, e);
    check("R1 oe", {15'd0, data_oe}, 16'd1);
    check("R7 flag", {15'd0, first_flag}, {15'd0, ef});
    @(negedge clk);
    check({req, " held"}, data_out, e);
    rd_n = 1;
    if (linked) cs_n = 1;
    #1 check("R1 idle zero", data_out, 16'd0);
    if (byte_mode) begin
      if (m_half) m_ptr = (m_ptr + 1) % NCH;
      m_half = ~m_half;
    end else begin
      m_ptr = (m_ptr + 1) % NCH;
      m_half = 0;
    end
  endtask

  task automatic stray_read();
    @(negedge clk);
    cs_n = 1; rd_n = 0;
    @(negedge clk);
    check("R11 oe", {15'd0, data_oe}, 16'd0);
    check("R11 data", data_out, 16'd0);
    check("R6 flag_oe", {15'd0, flag_oe}, 16'd0);
    rd_n = 1;
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) results[c*W +: W] = 16'h1111 * W'(c + 1);
    repeat (3) @(negedge clk);
    check("R10 oe", {15'd0, data_oe}, 16'd0);
    check("R6 flag_oe", {15'd0, flag_oe}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    cs_n = 0;
    @(negedge clk);
    check("R6 cs oe", {15'd0, flag_oe}, 16'd1);
    check("R10 flag low", {15'd0, first_flag}, 16'd0);
    // R10 R2 R3: word reads across the wrap
    for (int i = 0; i < NCH + 2; i++) do_read(0, "R2 R3 word");
    // R4 R5 hi first, R7 flag across both bytes
    byte_mode = 1; load(1);
    @(negedge clk); cs_n = 0;
    for (int i = 0; i < 4; i++) do_read(0, "R4 R5 byte hi");
    hi_first = 0; load(0);
    for (int i = 0; i < 4; i++) do_read(0, "R5 byte lo");
    // R9 restart mid pair
    do_read(0, "R4 byte");
    load(0);
    do_read(0, "R9 restart");
    stray_read();
    do_read(1, "R11 after stray");
    // R8 linked
    byte_mode = 0; load(0);
    for (int i = 0; i < NCH + 1; i++) do_read(1, "R8 linked");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int a = $urandom_range(9);
      if (a == 0) load(0);
      else if (a == 1) stray_read();
      else if (a == 2) begin
        @(negedge clk);
        byte_mode = 1'($urandom); hi_first = 1'($urandom);
      end else if (a == 3) do_read(1, "R8 rand linked");
      else begin
        @(negedge clk); cs_n = 0;
        do_read(0, "R2 R4 R5 rand");
      end
    end
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    check("R6 release", {15'd0, flag_oe}, 16'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule